// File: doc/BRIEF.md
# In-Order Event Latency Meter

This block measures how many clock cycles pass between a start event and the stop event that closes it. Events are assumed to finish in the order they began, so the block only has to remember when each open event started. A free-running cycle counter is sampled into a small timestamp queue on every accepted start. Each stop takes the oldest timestamp off the queue and subtracts it from the current counter value. The difference is one latency sample.

Every sample goes into an attached exponential histogram. The histogram keeps the smallest and largest sample, the running sum, the number of samples, and one counter per power-of-two bucket. A parameter sets the number of events that can be open at once. A second parameter, the largest expected latency, sets the counter and timestamp widths and the bucket count. A third parameter removes all measurement state; the strobes are then always accepted and nothing is recorded.

Top module: `lat_fifo_meter`

## Requirements
- R1: After reset, `start_ready` is 1, `err_underflow` is 0, and the count, sum, maximum and every bucket are 0. The minimum reads all ones, which is the value for an empty histogram.
- R2: Suppose a start is accepted at clock edge k and its stop is taken at edge k+d. Then the recorded sample is d, and the histogram outputs show it right after edge k+d.
- R3: When several events are open, each stop is paired with the oldest start that has not yet been paired.
- R4: Up to SLOTS events can be open at once. While SLOTS are open, `start_ready` is 0 and a start strobe is not accepted, so no timestamp is stored for it.
- R5: A stop that arrives while no event is open sets `err_underflow`. The flag stays at 1 until reset, and no sample is recorded for that stop.
- R6: A start and a stop in the same cycle are both handled. If events are already open, the stop pairs with the oldest one. If none are open, the stop is an underflow, and the new start stays open for a later stop.
- R7: After every sample, `hist_count` has risen by one and `hist_sum` by the sample. `hist_min` and `hist_max` are the smallest and largest samples recorded so far.
- R8: The histogram has TS_W+1 buckets:
  - Bucket 0 counts samples equal to 0.
  - Bucket i (i ≥ 1) counts samples v with 2^(i-1) ≤ v < 2^i.
  - Bucket i occupies bits [i*CNT_W +: CNT_W] of `hist_buckets`.
- R9: The timestamp width is TS_W, the number of bits needed to hold MAX_LAT. A true latency of d cycles is recorded as d mod 2^TS_W.
- R10: With ENABLE = 0, the block holds no state. `start_ready` is always 1, and `err_underflow` and all histogram outputs are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start-event strobe |
| start_ready | output | 1 | High when a start can be accepted |
| stop_valid | input | 1 | Stop-event strobe |
| err_underflow | output | 1 | Sticky flag: a stop arrived with no open event |
| hist_count | output | CNT_W | Number of samples recorded |
| hist_sum | output | SUM_W | Sum of all samples |
| hist_min | output | TS_W | Smallest sample (all ones when empty) |
| hist_max | output | TS_W | Largest sample |
| hist_buckets | output | (TS_W+1)*CNT_W | Bucket counters, bucket i at [i*CNT_W +: CNT_W] |

## Verification
The case hardest to reach from the ports is a true latency of exactly 2^TS_W cycles. It wraps to zero and is the only way to fill bucket 0. The stimulus reaches it by holding one event open for 511 idle cycles past its start edge. It then holds a second event for 600 cycles to check a wrapped nonzero value.

A stop that coincides with a start on an empty queue also needs a precise setup. The bench first drains the queue exactly, then issues both strobes on one edge. It then shows that the start survived by closing it later and checking that sample's latency.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Number of bits needed to hold the value v (at least one).
  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned r;
    r = 1;
    for (int i = 0; i < 32; i++)
      if (v[i]) r = i + 1;
    return r;
  endfunction

  // Exponential bucket index: 0 for zero, otherwise position of top set bit plus one.
  function automatic int unsigned exp_bucket(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++)
      if (v[i]) r = i + 1;
    return r;
  endfunction

  // Elapsed cycles between two counter samples, modulo 2^w.
  function automatic logic [31:0] wrap_diff(input logic [31:0] now_v,
                                            input logic [31:0] then_v,
                                            input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
    return (now_v - then_v) & mask;
  endfunction

endpackage

// File: rtl/lfm_stamp_ctr.sv
module lfm_stamp_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/lfm_stamp_fifo.sv
module lfm_stamp_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [W-1:0]      push_data,
  input  logic              pop,
  output logic [W-1:0]      head,
  output logic [FILL_W-1:0] fill,
  output logic              full,
  output logic              empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == FILL_W'(DEPTH));
  assign empty = (fill == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/lfm_exp_hist.sv
module lfm_exp_hist
  import lfm_pkg::*;
#(
  parameter int VAL_W = 9,
  parameter int CNT_W = 16,
  parameter int SUM_W = 32,
  localparam int NB   = VAL_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add,
  input  logic [VAL_W-1:0]    val,
  output logic [CNT_W-1:0]    count,
  output logic [SUM_W-1:0]    sum,
  output logic [VAL_W-1:0]    vmin,
  output logic [VAL_W-1:0]    vmax,
  output logic [NB*CNT_W-1:0] buckets
);
  int unsigned idx;
  assign idx = exp_bucket(32'(val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      sum   <= '0;
      vmin  <= '1;
      vmax  <= '0;
    end else if (add) begin
      count <= count + 1'b1;
      sum   <= sum + SUM_W'(val);
      if (val < vmin) vmin <= val;
      if (val > vmax) vmax <= val;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt <= '0;
      else if (add && idx == b)             cnt <= cnt + 1'b1;
    end
    assign buckets[b*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/lat_fifo_meter.sv
module lat_fifo_meter
  import lfm_pkg::*;
#(
  parameter int  SLOTS   = 4,
  parameter int  MAX_LAT = 300,
  parameter int  CNT_W   = 16,
  parameter int  SUM_W   = 32,
  parameter bit  ENABLE  = 1'b1,
  localparam int TS_W    = bits_for(MAX_LAT),
  localparam int NB      = TS_W + 1,
  localparam int FILL_W  = $clog2(SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic                stop_valid,
  output logic                err_underflow,
  output logic [CNT_W-1:0]    hist_count,
  output logic [SUM_W-1:0]    hist_sum,
  output logic [TS_W-1:0]     hist_min,
  output logic [TS_W-1:0]     hist_max,
  output logic [NB*CNT_W-1:0] hist_buckets
);
  // Named internal events, visible to the bound checker.
  logic [FILL_W-1:0] fill;
  logic              fifo_empty;
  logic              sample_en;
  logic [TS_W-1:0]   sample_val;

  if (ENABLE) begin : g_on
    logic [TS_W-1:0] now;
    logic [TS_W-1:0] head;
    logic            full;
    logic            push;

    lfm_stamp_ctr #(.W(TS_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .now(now)
    );

    assign push      = start_valid && !full;
    assign sample_en = stop_valid && !fifo_empty;

    lfm_stamp_fifo #(.DEPTH(SLOTS), .W(TS_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(now),
      .pop(sample_en), .head(head),
      .fill(fill), .full(full), .empty(fifo_empty)
    );

    assign sample_val  = TS_W'(wrap_diff(32'(now), 32'(head), TS_W));
    assign start_ready = !full;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        err_underflow <= 1'b0;
      else if (stop_valid && fifo_empty) err_underflow <= 1'b1;
    end

    lfm_exp_hist #(.VAL_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .add(sample_en), .val(sample_val),
      .count(hist_count), .sum(hist_sum),
      .vmin(hist_min), .vmax(hist_max),
      .buckets(hist_buckets)
    );
  end else begin : g_off
    assign fill          = '0;
    assign fifo_empty    = 1'b0;
    assign sample_en     = 1'b0;
    assign sample_val    = '0;
    assign start_ready   = 1'b1;
    assign err_underflow = 1'b0;
    assign hist_count    = '0;
    assign hist_sum      = '0;
    assign hist_min      = '0;
    assign hist_max      = '0;
    assign hist_buckets  = '0;
  end
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
  parameter int SLOTS  = 4,
  parameter int FILL_W = 3,
  parameter int CNT_W  = 16,
  parameter int TS_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              stop_valid,
  input logic              err_underflow,
  input logic [CNT_W-1:0]  hist_count,
  input logic [TS_W-1:0]   hist_min,
  input logic [TS_W-1:0]   hist_max,
  input logic [FILL_W-1:0] fill,
  input logic              fifo_empty,
  input logic              sample_en
);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(SLOTS));

  assert_full_blocks_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FILL_W'(SLOTS)) |-> !start_ready);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  assert_empty_stop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_valid && fifo_empty) |=> err_underflow);

  assert_no_sample_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !fifo_empty);

  assert_same_cycle_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && stop_valid && !fifo_empty) |=> (fill == $past(fill)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> (hist_count == $past(hist_count) + 1'b1));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(hist_count));

  assert_min_le_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_count != '0) |-> (hist_min <= hist_max));
endmodule

bind lat_fifo_meter lfm_checker #(
  .SLOTS(SLOTS), .FILL_W(FILL_W), .CNT_W(CNT_W), .TS_W(TS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_valid(start_valid), .start_ready(start_ready),
  .stop_valid(stop_valid), .err_underflow(err_underflow),
  .hist_count(hist_count), .hist_min(hist_min), .hist_max(hist_max),
  .fill(fill), .fifo_empty(fifo_empty), .sample_en(sample_en)
);

// File: tb/lat_fifo_meter_bench.sv
`timescale 1ns/1ps
module lat_fifo_meter_bench;
  localparam int SLOTS   = 4;
  localparam int MAX_LAT = 300;
  localparam int CNT_W   = 16;
  localparam int SUM_W   = 32;
  localparam int TS_W    = $clog2(MAX_LAT + 1);
  localparam int NB      = TS_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic stop_valid = 1'b0;
  always #2 clk = ~clk;

  logic                start_ready, err_underflow;
  logic [CNT_W-1:0]    hist_count;
  logic [SUM_W-1:0]    hist_sum;
  logic [TS_W-1:0]     hist_min, hist_max;
  logic [NB*CNT_W-1:0] hist_buckets;

  logic                o_ready, o_err;
  logic [CNT_W-1:0]    o_count;
  logic [SUM_W-1:0]    o_sum;
  logic [TS_W-1:0]     o_min, o_max;
  logic [NB*CNT_W-1:0] o_buckets;

  lat_fifo_meter #(.SLOTS(SLOTS), .MAX_LAT(MAX_LAT), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_lat_fifo_meter (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .stop_valid(stop_valid), .err_underflow(err_underflow),
    .hist_count(hist_count), .hist_sum(hist_sum), .hist_min(hist_min),
    .hist_max(hist_max), .hist_buckets(hist_buckets));

  lat_fifo_meter #(.SLOTS(SLOTS), .MAX_LAT(MAX_LAT), .CNT_W(CNT_W), .SUM_W(SUM_W), .ENABLE(1'b0)) u_lat_fifo_meter_off (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(o_ready),
    .stop_valid(stop_valid), .err_underflow(o_err),
    .hist_count(o_count), .hist_sum(o_sum), .hist_min(o_min),
    .hist_max(o_max), .hist_buckets(o_buckets));

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench model.
  longint edge_no = 0;
  longint open_q[$];
  longint m_cnt = 0, m_sum = 0, m_min = (1 << TS_W) - 1, m_max = 0;
  longint m_bkt [NB];
  bit     m_err = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bucket_of(input longint v);
    int b = 0;
    longint x = v;
    while (x > 0) begin x = x / 2; b++; end
    return b;
  endfunction

  task automatic record(input longint lat);
    m_cnt++;
    m_sum += lat;
    if (lat < m_min) m_min = lat;
    if (lat > m_max) m_max = lat;
    m_bkt[bucket_of(lat)]++;
  endtask

  // One clock edge with the given strobes; called and returning at a falling edge.
  task automatic tick(input logic s, input logic p);
    bit acc = s && start_ready;
    start_valid = s;
    stop_valid  = p;
    @(negedge clk);
    if (p) begin
      if (open_q.size() == 0) m_err = 1;
      else record((edge_no - open_q.pop_front()) % (longint'(1) << TS_W));
    end
    if (acc) open_q.push_back(edge_no);
    edge_no++;
    start_valid = 1'b0;
    stop_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic check_all(input string req);
    chk(req, "count", hist_count, m_cnt);
    chk(req, "sum", hist_sum, m_sum);
    chk(req, "min", hist_min, m_min);
    chk(req, "max", hist_max, m_max);
    chk(req, "err", err_underflow, m_err);
    for (int b = 0; b < NB; b++)
      chk("R8", $sformatf("bucket%0d", b), hist_buckets[b*CNT_W +: CNT_W], m_bkt[b]);
  endtask

  task automatic t_reset_R1;
    chk("R1", "start_ready", start_ready, 1);
    chk("R1", "err", err_underflow, 0);
    chk("R1", "count", hist_count, 0);
    chk("R1", "sum", hist_sum, 0);
    chk("R1", "max", hist_max, 0);
    chk("R1", "min all ones", hist_min, (1 << TS_W) - 1);
    chk("R1", "buckets", (hist_buckets == '0), 1);
  endtask

  task automatic t_single_R2;
    tick(1, 0); idle(4); tick(0, 1);
    chk("R2", "latency 5 as max", hist_max, 5);
    chk("R2", "one sample", hist_count, 1);
    chk("R8", "bucket3 holds 5", hist_buckets[3*CNT_W +: CNT_W], 1);
    check_all("R2");
  endtask

  task automatic t_order_R3;
    tick(1, 0); idle(2); tick(1, 0); idle(1); tick(0, 1);
    chk("R3", "oldest paired first (min)", hist_min, 5);
    idle(9); tick(0, 1);
    chk("R3", "second event latency as max", hist_max, 12);
    check_all("R3");
  endtask

  task automatic t_full_R4;
    longint c0 = m_cnt;
    for (int i = 0; i < SLOTS; i++) tick(1, 0);
    chk("R4", "ready low when full", start_ready, 0);
    tick(1, 0);
    chk("R4", "ready still low", start_ready, 0);
    for (int i = 0; i < SLOTS; i++) begin idle(2); tick(0, 1); end
    chk("R4", "ready back", start_ready, 1);
    chk("R4", "samples drained", hist_count, c0 + SLOTS);
    chk("R4", "no underflow, rejected start not stored", err_underflow, 0);
    check_all("R4");
  endtask

  task automatic t_underflow_R5;
    longint c0 = m_cnt;
    tick(0, 1);
    chk("R5", "err set", err_underflow, 1);
    chk("R5", "no sample", hist_count, c0);
    idle(3);
    chk("R5", "err sticky", err_underflow, 1);
    check_all("R5");
  endtask

  task automatic t_same_cycle_R6;
    longint c0 = m_cnt, s0;
    tick(1, 0); idle(2); tick(1, 1);
    chk("R6", "stop pairs with older start", hist_count, c0 + 1);
    idle(3); tick(0, 1);
    chk("R6", "new start kept", hist_count, c0 + 2);
    c0 = m_cnt;
    s0 = m_sum;
    tick(1, 1);
    chk("R6", "empty: no sample", hist_count, c0);
    idle(6); tick(0, 1);
    chk("R6", "empty: start kept, latency 7", hist_sum, s0 + 7);
    check_all("R6");
  endtask

  task automatic t_wrap_R9;
    longint s0;
    tick(1, 0); idle(511); tick(0, 1);
    chk("R9", "512 wraps to 0", hist_min, 0);
    chk("R8", "bucket0", hist_buckets[0 +: CNT_W], 1);
    s0 = m_sum;
    tick(1, 0); idle(599); tick(0, 1);
    chk("R9", "600 wraps to 88", hist_sum, s0 + 88);
    check_all("R9");
  endtask

  task automatic t_disabled_R10;
    tick(0, 1); tick(1, 0);
    chk("R10", "ready", o_ready, 1);
    chk("R10", "err", o_err, 0);
    chk("R10", "count", o_count, 0);
    chk("R10", "sum", o_sum, 0);
    chk("R10", "min/max", {o_min, o_max}, 0);
    chk("R10", "buckets", (o_buckets == '0), 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) m_bkt[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_single_R2();
    t_order_R3();
    t_full_R4();
    t_underflow_R5();
    t_same_cycle_R6();
    t_wrap_R9();
    t_disabled_R10();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule